// File: doc/BRIEF.md
# Dual CAM Slot Controller

This block sits between a byte-wide register port and two common-interface conditional-access module slots. Software first loads a 14-bit module address into two address registers. It then picks the slot and the address space (attribute memory or control) in a packed bus-control byte. Finally it reads or writes the data register, which runs one module access cycle on the slot bus. The electrical cycle is reduced to a fixed sequence: an address setup phase, a read or write strobe phase and a hold phase, each a parameterised number of clock cycles.

The same bus-control byte also starts a per-slot module reset, enables transport-stream pass-through per slot and reports card detect. A reset bit reads 1 while the reset is running and clears itself once the reset is finished. A second control byte drives two active-low tuner resets. Any change in the synchronised card-detect inputs raises a sticky interrupt, and reading the interrupt status register clears it.

Top module: `cam_slot_ctrl`

## Requirements
- R1: The module address on `cam_addr_o` is {address-high bits 6:0, address-low bits 7:1}; address-low bit 0 and address-high bit 7 are not stored and read back as 0 (register offsets: 0 address-low, 1 address-high).
- R2: Bus-control (offset 3) bit 7 selects the slot (0 = slot 0 on `cam_cs_o[0]`, 1 = slot 1 on `cam_cs_o[1]`) and bit 6 selects control space (1) or attribute memory (0) on `cam_space_o`; at most one chip select is active.
- R3: A write to the data register (offset 2) drives chip select for SETUP_CYC+STROBE_CYC+HOLD_CYC cycles and `cam_we_o` for STROBE_CYC cycles with the written byte on `cam_wdata_o`; `reg_ack_o` rises SETUP_CYC+STROBE_CYC+HOLD_CYC+1 clock edges after the request edge.
- R4: A read of the data register strobes `cam_oe_o` for STROBE_CYC cycles and returns the byte from the selected slot's `cam_rdata_i` lane (slot 0 bits 7:0, slot 1 bits 15:8) with the ack; any other register acks one edge after the request.
- R5: An access to a slot whose card detect reads absent asserts no chip select and no strobe, completes with the same latency and reads 0xFF.
- R6: Writing 1 to bus-control bit 5 (slot 0) or bit 4 (slot 1) drives that slot's `cam_rst_o` high for exactly RST_CYC cycles. The bit then keeps reading 1 until that slot's `cam_ready_i` is high, and reads 0 after that. Writing 0 to these bits has no effect.
- R7: Bus-control bit 3 drives `ts_en_o[0]` and bit 2 drives `ts_en_o[1]`; bits 7, 6, 3, 2 read back as written.
- R8: Bus-control bit 1 reads the synchronised `cam_cd_ni[0]` and bit 0 reads `cam_cd_ni[1]` (0 = module present); writes to bits 1:0 are ignored.
- R9: Second control register (offset 4) bit 3 drives `tuner_rst_no[0]` and bit 2 drives `tuner_rst_no[1]`; the other bits read 0 and the reset value holds both tuners in reset.
- R10: A change of either card-detect input sets `irq_o` two edges later; reading the status register (offset 5) returns 0x01 while pending and clears it, and 0x00 otherwise.
- R11: After reset no chip select, strobe, module reset, stream enable or interrupt is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| reg_req_i | input | 1 | Register access request, one cycle |
| reg_we_i | input | 1 | 1 = write, 0 = read |
| reg_addr_i | input | 3 | Register offset |
| reg_wdata_i | input | 8 | Write data |
| reg_ack_o | output | 1 | Access complete, one cycle |
| reg_rdata_o | output | 8 | Read data, valid with ack |
| irq_o | output | 1 | Card-detect change pending |
| cam_addr_o | output | 14 | Module address |
| cam_space_o | output | 1 | 1 = control space, 0 = attribute memory |
| cam_cs_o | output | 2 | Per-slot chip select |
| cam_we_o | output | 1 | Write strobe |
| cam_oe_o | output | 1 | Read strobe |
| cam_wdata_o | output | 8 | Module write data |
| cam_rdata_i | input | 16 | Module read data, one byte lane per slot |
| cam_cd_ni | input | 2 | Active-low card detect per slot, asynchronous |
| cam_ready_i | input | 2 | Module ready per slot |
| cam_rst_o | output | 2 | Module reset per slot |
| ts_en_o | output | 2 | Transport-stream pass-through enable per slot |
| tuner_rst_no | output | 2 | Active-low tuner resets |

## Verification
The bench picks an address whose low-register bit 0 is set, so a design that shifted the address wrongly or kept that bit would put a different value on the module bus during the write strobe. It counts strobe and chip-select cycles and the ack latency, so a sequencer with a phase one cycle short or long is caught. It reads a slot just after its card is removed, and a design that still selected it or returned the bus lane instead of 0xFF fails there. It keeps the module-ready input low after a slot reset. A reset bit that cleared on the pulse timer alone, or that pulsed the other slot, shows up in the read-back and the pulse count.

// File: rtl/cam_pkg.sv
package cam_pkg;
  localparam int REG_AW = 3;

  localparam logic [REG_AW-1:0] OFS_ADDR_LO = 3'd0;
  localparam logic [REG_AW-1:0] OFS_ADDR_HI = 3'd1;
  localparam logic [REG_AW-1:0] OFS_DATA    = 3'd2;
  localparam logic [REG_AW-1:0] OFS_CTRL    = 3'd3;
  localparam logic [REG_AW-1:0] OFS_CTRL2   = 3'd4;
  localparam logic [REG_AW-1:0] OFS_IRQ     = 3'd5;

  // bus-control bit positions
  localparam int B_SLOT   = 7;
  localparam int B_SPACE  = 6;
  localparam int B_RST0   = 5;
  localparam int B_RST1   = 4;
  localparam int B_TS0    = 3;
  localparam int B_TS1    = 2;
  localparam int B_CD0    = 1;
  localparam int B_CD1    = 0;
  // second control register
  localparam int B_TUN1   = 3;
  localparam int B_TUN2   = 2;

  localparam int CAM_AW   = 14;
  localparam int NSLOT    = 2;

  typedef enum logic [1:0] {
    ACC_IDLE,
    ACC_SETUP,
    ACC_STROBE,
    ACC_HOLD
  } acc_state_e;

  typedef enum logic [1:0] {
    RS_IDLE,
    RS_PULSE,
    RS_WAIT
  } rst_state_e;
endpackage

// File: rtl/cam_slot_reset.sv
module cam_slot_reset #(
  parameter int RST_CYC = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic ready_i,
  output logic busy_o,
  output logic cam_rst_o
);
  import cam_pkg::*;

  localparam int CW = $clog2(RST_CYC + 1);

  rst_state_e       state_q;
  logic [CW-1:0]    cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= RS_IDLE;
      cnt_q   <= '0;
    end else begin
      unique case (state_q)
        RS_IDLE: if (start_i) begin
          state_q <= RS_PULSE;
          cnt_q   <= CW'(RST_CYC - 1);
        end
        RS_PULSE: begin
          if (cnt_q == '0) state_q <= RS_WAIT;
          else             cnt_q   <= cnt_q - 1'b1;
        end
        RS_WAIT: if (ready_i) state_q <= RS_IDLE;
        default: state_q <= RS_IDLE;
      endcase
    end
  end

  assign busy_o    = (state_q != RS_IDLE);
  assign cam_rst_o = (state_q == RS_PULSE);
endmodule

// File: rtl/cam_access_seq.sv
module cam_access_seq #(
  parameter int SETUP_CYC  = 2,
  parameter int STROBE_CYC = 3,
  parameter int HOLD_CYC   = 1
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       start_i,
  input  logic                       we_i,
  input  logic                       slot_i,
  input  logic                       space_i,
  input  logic [cam_pkg::CAM_AW-1:0] addr_i,
  input  logic [7:0]                 wdata_i,
  input  logic [cam_pkg::NSLOT-1:0]  present_i,
  input  logic [8*cam_pkg::NSLOT-1:0] cam_rdata_i,
  output logic                       busy_o,
  output logic                       done_o,
  output logic [7:0]                 rdata_o,
  output logic [cam_pkg::CAM_AW-1:0] cam_addr_o,
  output logic                       cam_space_o,
  output logic [cam_pkg::NSLOT-1:0]  cam_cs_o,
  output logic                       cam_we_o,
  output logic                       cam_oe_o,
  output logic [7:0]                 cam_wdata_o
);
  import cam_pkg::*;

  localparam int MAXC = (SETUP_CYC > STROBE_CYC)
                        ? ((SETUP_CYC > HOLD_CYC) ? SETUP_CYC : HOLD_CYC)
                        : ((STROBE_CYC > HOLD_CYC) ? STROBE_CYC : HOLD_CYC);
  localparam int CW   = $clog2(MAXC + 1);

  acc_state_e          state_q;
  logic [CW-1:0]       cnt_q;
  logic                we_q, slot_q, space_q, hit_q, done_q;
  logic [CAM_AW-1:0]   addr_q;
  logic [7:0]          wdata_q, rdata_q;
  logic                last;

  assign last = (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ACC_IDLE;
      cnt_q   <= '0;
      we_q    <= 1'b0;
      slot_q  <= 1'b0;
      space_q <= 1'b0;
      hit_q   <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
      rdata_q <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        ACC_IDLE: if (start_i) begin
          state_q <= ACC_SETUP;
          cnt_q   <= CW'(SETUP_CYC - 1);
          we_q    <= we_i;
          slot_q  <= slot_i;
          space_q <= space_i;
          hit_q   <= present_i[slot_i];
          addr_q  <= addr_i;
          wdata_q <= wdata_i;
        end
        ACC_SETUP: begin
          if (last) begin
            state_q <= ACC_STROBE;
            cnt_q   <= CW'(STROBE_CYC - 1);
          end else cnt_q <= cnt_q - 1'b1;
        end
        ACC_STROBE: begin
          if (last) begin
            state_q <= ACC_HOLD;
            cnt_q   <= CW'(HOLD_CYC - 1);
            if (!we_q)
              rdata_q <= hit_q ? cam_rdata_i[{slot_q, 3'b000} +: 8] : 8'hFF;
          end else cnt_q <= cnt_q - 1'b1;
        end
        ACC_HOLD: begin
          if (last) begin
            state_q <= ACC_IDLE;
            done_q  <= 1'b1;
          end else cnt_q <= cnt_q - 1'b1;
        end
        default: state_q <= ACC_IDLE;
      endcase
    end
  end

  logic active, strobe;
  assign active = (state_q != ACC_IDLE) && hit_q;
  assign strobe = (state_q == ACC_STROBE) && hit_q;

  for (genvar s = 0; s < NSLOT; s++) begin : g_cs
    assign cam_cs_o[s] = active && (slot_q == s[0]);
  end

  assign busy_o      = (state_q != ACC_IDLE);
  assign done_o      = done_q;
  assign rdata_o     = rdata_q;
  assign cam_addr_o  = addr_q;
  assign cam_space_o = space_q;
  assign cam_we_o    = strobe && we_q;
  assign cam_oe_o    = strobe && !we_q;
  assign cam_wdata_o = wdata_q;
endmodule

// File: rtl/cam_regs.sv
module cam_regs (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       req_i,
  input  logic                       we_i,
  input  logic [cam_pkg::REG_AW-1:0] addr_i,
  input  logic [7:0]                 wdata_i,
  input  logic                       acc_busy_i,
  input  logic [cam_pkg::NSLOT-1:0]  cd_ni,
  input  logic [cam_pkg::NSLOT-1:0]  rst_busy_i,
  output logic                       ack_o,
  output logic [7:0]                 rdata_o,
  output logic                       acc_start_o,
  output logic                       acc_slot_o,
  output logic                       acc_space_o,
  output logic [cam_pkg::CAM_AW-1:0] acc_addr_o,
  output logic [cam_pkg::NSLOT-1:0]  present_o,
  output logic [cam_pkg::NSLOT-1:0]  rst_start_o,
  output logic [cam_pkg::NSLOT-1:0]  ts_en_o,
  output logic [cam_pkg::NSLOT-1:0]  tuner_rst_no,
  output logic                       irq_o
);
  import cam_pkg::*;

  logic [6:0]       addr_lo_q, addr_hi_q;
  logic             slot_q, space_q;
  logic [NSLOT-1:0] ts_q, tun_q;
  logic [NSLOT-1:0] cd_a_q, cd_b_q;
  logic             pend_q, ack_q;
  logic [7:0]       rdata_q, rd_mux, ctrl_rd;
  logic             take, wr, rd, cd_chg;

  assign take   = req_i && !acc_busy_i;
  assign wr     = take && we_i;
  assign rd     = take && !we_i;
  assign cd_chg = |(cd_a_q ^ cd_b_q);

  assign ctrl_rd = {slot_q, space_q, rst_busy_i[0], rst_busy_i[1],
                    ts_q[0], ts_q[1], cd_b_q[0], cd_b_q[1]};

  always_comb begin
    unique case (addr_i)
      OFS_ADDR_LO: rd_mux = {addr_lo_q, 1'b0};
      OFS_ADDR_HI: rd_mux = {1'b0, addr_hi_q};
      OFS_CTRL:    rd_mux = ctrl_rd;
      OFS_CTRL2:   rd_mux = {4'b0, tun_q[0], tun_q[1], 2'b0};
      OFS_IRQ:     rd_mux = {7'b0, pend_q};
      default:     rd_mux = 8'h00;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_lo_q <= '0;
      addr_hi_q <= '0;
      slot_q    <= 1'b0;
      space_q   <= 1'b0;
      ts_q      <= '0;
      tun_q     <= '0;
      cd_a_q    <= '1;
      cd_b_q    <= '1;
      pend_q    <= 1'b0;
      ack_q     <= 1'b0;
      rdata_q   <= '0;
    end else begin
      cd_a_q <= cd_ni;
      cd_b_q <= cd_a_q;
      ack_q  <= take && (addr_i != OFS_DATA);
      if (rd) rdata_q <= rd_mux;
      if (cd_chg)                        pend_q <= 1'b1;
      else if (rd && addr_i == OFS_IRQ)  pend_q <= 1'b0;
      if (wr) begin
        unique case (addr_i)
          OFS_ADDR_LO: addr_lo_q <= wdata_i[7:1];
          OFS_ADDR_HI: addr_hi_q <= wdata_i[6:0];
          OFS_CTRL: begin
            slot_q  <= wdata_i[B_SLOT];
            space_q <= wdata_i[B_SPACE];
            ts_q    <= {wdata_i[B_TS1], wdata_i[B_TS0]};
          end
          OFS_CTRL2: tun_q <= {wdata_i[B_TUN2], wdata_i[B_TUN1]};
          default: ;
        endcase
      end
    end
  end

  assign ack_o        = ack_q;
  assign rdata_o      = rdata_q;
  assign acc_start_o  = take && (addr_i == OFS_DATA);
  assign acc_slot_o   = slot_q;
  assign acc_space_o  = space_q;
  assign acc_addr_o   = {addr_hi_q, addr_lo_q};
  assign present_o    = ~cd_b_q;
  assign rst_start_o  = {2{wr && addr_i == OFS_CTRL}} &
                        {wdata_i[B_RST1], wdata_i[B_RST0]};
  assign ts_en_o      = ts_q;
  assign tuner_rst_no = tun_q;
  assign irq_o        = pend_q;
endmodule

// File: rtl/cam_slot_ctrl.sv
module cam_slot_ctrl #(
  parameter int SETUP_CYC  = 2,
  parameter int STROBE_CYC = 3,
  parameter int HOLD_CYC   = 1,
  parameter int RST_CYC    = 16
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        reg_req_i,
  input  logic        reg_we_i,
  input  logic [2:0]  reg_addr_i,
  input  logic [7:0]  reg_wdata_i,
  output logic        reg_ack_o,
  output logic [7:0]  reg_rdata_o,
  output logic        irq_o,
  output logic [13:0] cam_addr_o,
  output logic        cam_space_o,
  output logic [1:0]  cam_cs_o,
  output logic        cam_we_o,
  output logic        cam_oe_o,
  output logic [7:0]  cam_wdata_o,
  input  logic [15:0] cam_rdata_i,
  input  logic [1:0]  cam_cd_ni,
  input  logic [1:0]  cam_ready_i,
  output logic [1:0]  cam_rst_o,
  output logic [1:0]  ts_en_o,
  output logic [1:0]  tuner_rst_no
);
  import cam_pkg::*;

  logic              acc_busy, acc_done, acc_start, acc_slot, acc_space;
  logic [7:0]        acc_rdata, regs_rdata;
  logic [CAM_AW-1:0] acc_addr;
  logic [NSLOT-1:0]  present, rst_start, rst_busy;
  logic              regs_ack;

  cam_regs u_regs (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .req_i        (reg_req_i),
    .we_i         (reg_we_i),
    .addr_i       (reg_addr_i),
    .wdata_i      (reg_wdata_i),
    .acc_busy_i   (acc_busy),
    .cd_ni        (cam_cd_ni),
    .rst_busy_i   (rst_busy),
    .ack_o        (regs_ack),
    .rdata_o      (regs_rdata),
    .acc_start_o  (acc_start),
    .acc_slot_o   (acc_slot),
    .acc_space_o  (acc_space),
    .acc_addr_o   (acc_addr),
    .present_o    (present),
    .rst_start_o  (rst_start),
    .ts_en_o      (ts_en_o),
    .tuner_rst_no (tuner_rst_no),
    .irq_o        (irq_o)
  );

  cam_access_seq #(
    .SETUP_CYC  (SETUP_CYC),
    .STROBE_CYC (STROBE_CYC),
    .HOLD_CYC   (HOLD_CYC)
  ) u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (acc_start),
    .we_i        (reg_we_i),
    .slot_i      (acc_slot),
    .space_i     (acc_space),
    .addr_i      (acc_addr),
    .wdata_i     (reg_wdata_i),
    .present_i   (present),
    .cam_rdata_i (cam_rdata_i),
    .busy_o      (acc_busy),
    .done_o      (acc_done),
    .rdata_o     (acc_rdata),
    .cam_addr_o  (cam_addr_o),
    .cam_space_o (cam_space_o),
    .cam_cs_o    (cam_cs_o),
    .cam_we_o    (cam_we_o),
    .cam_oe_o    (cam_oe_o),
    .cam_wdata_o (cam_wdata_o)
  );

  for (genvar s = 0; s < NSLOT; s++) begin : g_rst
    cam_slot_reset #(.RST_CYC(RST_CYC)) u_rst (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .start_i   (rst_start[s]),
      .ready_i   (cam_ready_i[s]),
      .busy_o    (rst_busy[s]),
      .cam_rst_o (cam_rst_o[s])
    );
  end

  assign reg_ack_o   = regs_ack | acc_done;
  assign reg_rdata_o = acc_done ? acc_rdata : regs_rdata;
endmodule

// File: rtl/cam_slot_ctrl_chk.sv
module cam_slot_ctrl_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        reg_req_i,
  input logic        reg_we_i,
  input logic [2:0]  reg_addr_i,
  input logic        reg_ack_o,
  input logic        irq_o,
  input logic [13:0] cam_addr_o,
  input logic [1:0]  cam_cs_o,
  input logic        cam_we_o,
  input logic        cam_oe_o
);
  AST_CS_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(cam_cs_o)); // R2

  AST_STROBE_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(cam_we_o && cam_oe_o)); // R3

  AST_STROBE_NEEDS_CS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cam_we_o || cam_oe_o) |-> (|cam_cs_o)); // R5

  AST_ADDR_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((|cam_cs_o) && $past(|cam_cs_o)) |-> $stable(cam_addr_o)); // R1

  AST_ACK_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_ack_o |=> !reg_ack_o); // R4

  AST_IRQ_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o && !(reg_req_i && !reg_we_i && reg_addr_i == 3'd5)) |=> irq_o); // R10
endmodule

bind cam_slot_ctrl cam_slot_ctrl_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .reg_req_i  (reg_req_i),
  .reg_we_i   (reg_we_i),
  .reg_addr_i (reg_addr_i),
  .reg_ack_o  (reg_ack_o),
  .irq_o      (irq_o),
  .cam_addr_o (cam_addr_o),
  .cam_cs_o   (cam_cs_o),
  .cam_we_o   (cam_we_o),
  .cam_oe_o   (cam_oe_o)
);

// File: tb/sim_cam_slot_ctrl.sv
`timescale 1ns/1ps
module sim_cam_slot_ctrl;
  localparam int SU = 2, ST = 3, HO = 1, RC = 16;
  localparam int ACC_LAT = SU + ST + HO + 1;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0, we = 1'b0;
  logic [2:0]  addr = '0;
  logic [7:0]  wdata = '0;
  logic        ack, irq, space, cwe, coe;
  logic [7:0]  rdata, cwd;
  logic [13:0] caddr;
  logic [1:0]  cs, crst, ts, tun;
  logic [15:0] crd = 16'h3CA5;
  logic [1:0]  cd_n = 2'b11, ready = 2'b00;

  always #2 clk = ~clk;

  cam_slot_ctrl #(.SETUP_CYC(SU), .STROBE_CYC(ST), .HOLD_CYC(HO), .RST_CYC(RC)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .reg_req_i(req), .reg_we_i(we),
    .reg_addr_i(addr), .reg_wdata_i(wdata), .reg_ack_o(ack), .reg_rdata_o(rdata),
    .irq_o(irq), .cam_addr_o(caddr), .cam_space_o(space), .cam_cs_o(cs),
    .cam_we_o(cwe), .cam_oe_o(coe), .cam_wdata_o(cwd), .cam_rdata_i(crd),
    .cam_cd_ni(cd_n), .cam_ready_i(ready), .cam_rst_o(crst), .ts_en_o(ts),
    .tuner_rst_no(tun));

  int n_chk = 0, n_fail = 0;
  int cs_cnt = 0, we_cnt = 0, oe_cnt = 0, r0_cnt = 0, r1_cnt = 0;
  logic [13:0] cap_addr; logic cap_space; logic [1:0] cap_cs; logic [7:0] cap_wd;

  always @(negedge clk) begin
    if (|cs) cs_cnt++;
    if (cwe || coe) begin
      cap_addr = caddr; cap_space = space; cap_cs = cs; cap_wd = cwd;
    end
    if (cwe) we_cnt++;
    if (coe) oe_cnt++;
    if (crst[0]) r0_cnt++;
    if (crst[1]) r1_cnt++;
  end

  task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", rq, act, exp);
    end
  endtask

  task automatic reg_op(input logic w, input logic [2:0] a, input logic [7:0] d,
                        output logic [7:0] q, output int lat);
    @(negedge clk);
    req = 1'b1; we = w; addr = a; wdata = d;
    lat = 0;
    forever begin
      @(negedge clk);
      req = 1'b0;
      lat++;
      if (ack || lat > 50) break;
    end
    q = rdata;
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    logic [7:0] q; int l;
    reg_op(1'b1, a, d, q, l);
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] q);
    int l;
    reg_op(1'b0, a, 8'h00, q, l);
  endtask

  task automatic wait_cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // {we, addr[2:0], wdata[7:0], expected read[7:0]}
  localparam logic [19:0] VEC [10] = '{
    {1'b1, 3'd0, 8'hAB, 8'h00},
    {1'b0, 3'd0, 8'h00, 8'hAA},   // R1 bit 0 dropped
    {1'b1, 3'd1, 8'hD5, 8'h00},
    {1'b0, 3'd1, 8'h00, 8'h55},   // R1 bit 7 dropped
    {1'b1, 3'd4, 8'hFF, 8'h00},
    {1'b0, 3'd4, 8'h00, 8'h0C},   // R9 only bits 3:2
    {1'b1, 3'd3, 8'hCC, 8'h00},
    {1'b0, 3'd3, 8'h00, 8'hCF},   // R7 stored bits, no card
    {1'b1, 3'd3, 8'h00, 8'h00},
    {1'b0, 3'd3, 8'h00, 8'h03}    // R8 bits 1:0 read card absent
  };

  bit done = 1'b0;

  initial begin
    #(200000 * 4);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [7:0] q; int lat; int b_cs, b_we, b_oe;
    wait_cyc(3);
    rst_n = 1'b1;
    wait_cyc(2);
    // R11 reset state
    chk("R11 cs", {30'b0, cs}, 0);
    chk("R11 rst/ts", {28'b0, crst, ts}, 0);
    chk("R11 strobes/irq", {29'b0, cwe, coe, irq}, 0);
    chk("R9 tuner reset value", {30'b0, tun}, 0);

    foreach (VEC[i]) begin
      reg_op(VEC[i][19], VEC[i][18:16], VEC[i][15:8], q, lat);
      chk(VEC[i][19] ? "R4 write ack latency" : "R4 read ack latency", lat, 1);
      if (!VEC[i][19]) chk("R1/R7/R8/R9 table readback", {24'b0, q}, {24'b0, VEC[i][7:0]});
    end

    wr(3'd3, 8'h08);
    chk("R7 ts enable slot0", {30'b0, ts}, 32'h1);
    wr(3'd3, 8'h04);
    chk("R7 ts enable slot1", {30'b0, ts}, 32'h2);
    wr(3'd4, 8'h08);
    chk("R9 tuner1", {30'b0, tun}, 32'h1);
    wr(3'd4, 8'h04);
    chk("R9 tuner2", {30'b0, tun}, 32'h2);

    // R10 card insertion
    @(negedge clk); cd_n = 2'b00;
    @(negedge clk);
    chk("R10 irq not yet", {31'b0, irq}, 0);
    @(negedge clk);
    chk("R10 irq raised", {31'b0, irq}, 1);
    rd(3'd3, q);
    chk("R8 card present bits", {30'b0, q[1:0]}, 0);
    rd(3'd5, q);
    chk("R10 status pending", {24'b0, q}, 32'h01);
    chk("R10 irq cleared", {31'b0, irq}, 0);
    rd(3'd5, q);
    chk("R10 status clear", {24'b0, q}, 32'h00);

    // R3 write to slot1 control space
    wr(3'd0, 8'h35);
    wr(3'd1, 8'h2B);
    wr(3'd3, 8'hC0);
    @(negedge clk); #1;
    b_cs = cs_cnt; b_we = we_cnt;
    reg_op(1'b1, 3'd2, 8'h5A, q, lat);
    #1;
    chk("R3 ack latency", lat, ACC_LAT);
    chk("R3 strobe length", we_cnt - b_we, ST);
    chk("R3 select length", cs_cnt - b_cs, SU + ST + HO);
    chk("R3 write data", {24'b0, cap_wd}, 32'h5A);
    chk("R1 module address", {18'b0, cap_addr}, 32'h159A);
    chk("R2 slot1 select", {30'b0, cap_cs}, 32'h2);
    chk("R2 control space", {31'b0, cap_space}, 1);

    // R4 read from slot0 attribute memory, then slot1
    wr(3'd3, 8'h00);
    @(negedge clk); #1;
    b_oe = oe_cnt;
    reg_op(1'b0, 3'd2, 8'h00, q, lat);
    #1;
    chk("R4 read byte slot0", {24'b0, q}, 32'hA5);
    chk("R4 read strobe length", oe_cnt - b_oe, ST);
    chk("R2 slot0 select", {30'b0, cap_cs}, 32'h1);
    chk("R2 attribute space", {31'b0, cap_space}, 0);
    wr(3'd3, 8'h80);
    rd(3'd2, q);
    chk("R4 read byte slot1", {24'b0, q}, 32'h3C);

    // R5 empty slot
    @(negedge clk); cd_n = 2'b01;
    wait_cyc(3);
    rd(3'd5, q);
    wr(3'd3, 8'h00);
    @(negedge clk); #1;
    b_cs = cs_cnt; b_oe = oe_cnt;
    reg_op(1'b0, 3'd2, 8'h00, q, lat);
    #1;
    chk("R5 empty slot reads FF", {24'b0, q}, 32'hFF);
    chk("R5 no select on empty slot", cs_cnt - b_cs + oe_cnt - b_oe, 0);
    chk("R5 latency unchanged", lat, ACC_LAT);

    // R6 slot1 reset
    wr(3'd3, 8'h00);
    chk("R6 write 0 no reset", {30'b0, crst}, 0);
    wr(3'd3, 8'h10);
    wait_cyc(RC + 4);
    chk("R6 pulse length slot1", r1_cnt, RC);
    chk("R6 other slot untouched", r0_cnt, 0);
    rd(3'd3, q);
    chk("R6 bit holds until ready", {31'b0, q[4]}, 1);
    @(negedge clk); ready = 2'b10;
    wait_cyc(2);
    rd(3'd3, q);
    chk("R6 bit cleared after ready", {31'b0, q[4]}, 0);
    chk("R6 module reset released", {30'b0, crst}, 0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule